// File: doc/BRIEF.md
# Dual-Compare Timer with PWM

An 8-bit timer/counter with two compare channels, A and B. The count moves only on a cycle where the count-enable strobe (`tick`) is high. That strobe comes from a prescaler outside the block. Four counting modes are supported:

- a free-running count that wraps;
- a count that clears after it matches compare A, which gives a programmable period;
- a symmetric up/down count whose top is fixed at 0xFF;
- a symmetric up/down count whose top is compare A.

Each channel drives one waveform pin. Each match also raises a sticky flag, and a third sticky flag marks overflow or the return to zero.

Software uses a small write port to load the count, the two compare values and the control bits. The same port clears flags: writing a one to a flag's bit clears it. The current count is visible on the `count` output. In the up/down modes, compare writes are held in a buffer and only take effect when the counter turns at its top. This keeps the PWM output free of glitches.

Top module: `dual_cmp_timer`

## Requirements
- R1: After a synchronous active-low reset, all of the following are zero: `count`, both waveform pins, all three flags, the control register and both compare values. The count direction is set to up.
- R2: Mode 0 (control bits [1:0] = 0) counts up by one on each tick and holds when `tick` is low. It wraps from 0xFF to 0x00, and the tick taken at 0xFF sets `irq_ovf`.
- R3: Mode 1 is clear-on-match. A tick taken while the count equals compare A loads 0x00. Otherwise the count advances by one. The tick at 0xFF also sets `irq_ovf`.
- R4: In modes 0 and 1, an enabled channel's waveform pin toggles on each match of that channel. A match is a tick taken while the count equals the channel's compare value.
- R5: Modes 2 and 3 count up, and at top they turn to count down. Top is 0xFF in mode 2 and compare A in mode 3. The tick taken at top loads top−1. Counting down to 0x00, the tick taken at 0x00 loads 0x01, sets `irq_ovf`, and turns the count back to up.
- R6: In modes 2 and 3, an enabled channel's pin goes low on a match taken while counting up, and high on a match taken while counting down. The exception is channel A in mode 3, which toggles on each match.
- R7: In modes 2 and 3, a written compare value takes effect only after the tick taken at top. In modes 0 and 1 it takes effect on the next cycle.
- R8: Each match sets that channel's flag (`irq_cmp_a`, `irq_cmp_b`), whether or not its output is enabled.
- R9: Address 4 clears flags when a one is written to the flag's bit: bit 0 for overflow, bit 1 for A, bit 2 for B. A hardware set in the same cycle wins over the clear.
- R10: A count write (address 0) wins over a tick in the same cycle. The first tick after a count write produces no compare match, although the count still advances.
- R11: A channel whose enable is 0 holds its pin. The enables are control bit 2 for A and bit 3 for B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Single-cycle count enable from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address: 0 count, 1 compare A, 2 compare B, 3 control, 4 flag clear |
| wr_data | input | 8 | Write data |
| count | output | 8 | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| irq_ovf | output | 1 | Sticky overflow / bottom flag |
| irq_cmp_a | output | 1 | Sticky compare A flag |
| irq_cmp_b | output | 1 | Sticky compare B flag |

## Verification
The bench builds the block with its default 8-bit width and two channels. With that width, a full wrap takes 256 ticks and an up/down cycle takes 510 ticks. Random runs of a few tens of thousands of cycles therefore cross every top, bottom and wrap many times. They also meet mode changes, compare writes that land mid-period, and count writes on the tick that would have matched.

// File: rtl/timer_pkg.sv
// Package: shared mode encoding and write-port address map for the dual compare timer.
// Assumes a 3-bit write address.
package timer_pkg;

    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_CLEAR    = 2'd1,
        MODE_PWM_FULL = 2'd2,
        MODE_PWM_CMPA = 2'd3
    } tmr_mode_e;

    localparam int          AW         = 3;
    localparam logic [AW-1:0] ADDR_COUNT = 3'd0;
    localparam logic [AW-1:0] ADDR_CMPA  = 3'd1;
    localparam logic [AW-1:0] ADDR_CMPB  = 3'd2;
    localparam logic [AW-1:0] ADDR_CTL   = 3'd3;
    localparam logic [AW-1:0] ADDR_FLAGS = 3'd4;

    localparam int NFLAG = 3;   // bit0 overflow, bit1 compare A, bit2 compare B

endpackage

// File: rtl/dct_regs.sv
// Module: register file of the timer. Holds the control bits and the compare buffers.
// In up/down modes each compare buffer is copied into an active register only at top.
// In other modes the buffer is used directly. Decodes count-write and flag-clear strobes.
// Assumes a single write per cycle.
module dct_regs
    import timer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            load_top,
    output tmr_mode_e       mode,
    output logic [1:0]      out_en,
    output logic [DW-1:0]   cmp_a,
    output logic [DW-1:0]   cmp_b,
    output logic            cnt_wr,
    output logic [NFLAG-1:0] clr_mask
);

    logic [3:0]    ctl_q;
    logic [DW-1:0] buf_a_q, buf_b_q, act_a_q, act_b_q;
    logic          pwm;

    assign mode   = tmr_mode_e'(ctl_q[1:0]);
    assign out_en = ctl_q[3:2];
    assign pwm    = ctl_q[1];

    // Software writes to control and compare buffers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q   <= '0;
            buf_a_q <= '0;
            buf_b_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CTL)  ctl_q   <= wr_data[3:0];
            if (wr_addr == ADDR_CMPA) buf_a_q <= wr_data;
            if (wr_addr == ADDR_CMPB) buf_b_q <= wr_data;
        end
    end

    // Active compare copies: follow the buffer outside PWM, load at top inside PWM
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_a_q <= '0;
            act_b_q <= '0;
        end else if (!pwm || load_top) begin
            act_a_q <= buf_a_q;
            act_b_q <= buf_b_q;
        end
    end

    // Effective compare values and write-port strobes
    always_comb begin
        cmp_a    = pwm ? act_a_q : buf_a_q;
        cmp_b    = pwm ? act_b_q : buf_b_q;
        cnt_wr   = wr_en && (wr_addr == ADDR_COUNT);
        clr_mask = (wr_en && (wr_addr == ADDR_FLAGS)) ? wr_data[NFLAG-1:0] : '0;
    end

    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !load_top) |=> ($stable(act_a_q) && $stable(act_b_q))) else $error("active compare changed off top"); // R7

endmodule

// File: rtl/dct_core.sv
// Module: counter and direction logic. Advances on tick in the selected mode.
// Reports compare matches, overflow/bottom and the turn at top.
// Assumes a count write wins over a tick, and the first tick after a count write produces no match.
module dct_core
    import timer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  tmr_mode_e     mode,
    input  logic [DW-1:0] cmp_a,
    input  logic [DW-1:0] cmp_b,
    input  logic          cnt_wr,
    input  logic [DW-1:0] cnt_wdata,
    output logic [DW-1:0] cnt,
    output logic          dir_up,
    output logic [1:0]    match,
    output logic          ovf_evt,
    output logic          at_top
);

    localparam logic [DW-1:0] MAXV = {DW{1'b1}};
    localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};

    logic [DW-1:0] top, cnt_nxt;
    logic          dir_nxt, supp_q, adv;

    assign adv = tick && !cnt_wr;

    // Top value for the current mode
    always_comb begin
        top = (mode == MODE_CLEAR || mode == MODE_PWM_CMPA) ? cmp_a : MAXV;
    end

    // Next count, direction and events for a tick
    always_comb begin
        cnt_nxt = cnt + ONE;
        dir_nxt = dir_up;
        ovf_evt = 1'b0;
        at_top  = 1'b0;
        unique case (mode)
            MODE_NORMAL: ovf_evt = adv && (cnt == MAXV);
            MODE_CLEAR: begin
                ovf_evt = adv && (cnt == MAXV);
                if (cnt == top) cnt_nxt = '0;
            end
            default: begin
                if (dir_up) begin
                    if (cnt >= top) begin
                        dir_nxt = 1'b0;
                        at_top  = adv;
                        cnt_nxt = (cnt == '0) ? '0 : cnt - ONE;
                    end
                end else if (cnt == '0) begin
                    dir_nxt = 1'b1;
                    ovf_evt = adv;
                    cnt_nxt = (top == '0) ? '0 : ONE;
                end else begin
                    cnt_nxt = cnt - ONE;
                end
            end
        endcase
    end

    // Compare matches, gated by the post-write suppression
    always_comb begin
        match[0] = adv && !supp_q && (cnt == cmp_a);
        match[1] = adv && !supp_q && (cnt == cmp_b);
    end

    // Counter, direction and suppression state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            dir_up <= 1'b1;
            supp_q <= 1'b0;
        end else if (cnt_wr) begin
            cnt    <= cnt_wdata;
            supp_q <= 1'b1;
        end else if (tick) begin
            cnt    <= cnt_nxt;
            dir_up <= dir_nxt;
            supp_q <= 1'b0;
        end
    end

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt)) else $error("count moved without tick"); // R2

    AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_CLEAR && adv && cnt == cmp_a) |=> (cnt == '0)) else $error("no clear after compare A"); // R3

    AST_BOTTOM_TURN: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && adv && !dir_up && cnt == '0) |=> dir_up) else $error("no turn at bottom"); // R5

endmodule

// File: rtl/dct_wave.sv
// Module: waveform outputs, one generated block per channel.
// Toggles on a match in the frequency modes. In up/down modes it clears on an up match and sets on a down match.
// Channel 0 toggles when it defines top. Assumes channel 0 is compare A.
module dct_wave
    import timer_pkg::*;
#(
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  tmr_mode_e      mode,
    input  logic           dir_up,
    input  logic [NCH-1:0] match,
    input  logic [NCH-1:0] out_en,
    output logic [NCH-1:0] wave
);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic pwm_rule;
        assign pwm_rule = mode[1] && !((ch == 0) && (mode == MODE_PWM_CMPA));

        // Update one channel's pin on an enabled match
        always_ff @(posedge clk) begin
            if (!rst_n)                        wave[ch] <= 1'b0;
            else if (match[ch] && out_en[ch])  wave[ch] <= pwm_rule ? !dir_up : !wave[ch];
        end

        AST_WAVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
            !(match[ch] && out_en[ch]) |=> $stable(wave[ch])) else $error("pin moved without enabled match"); // R11
    end

endmodule

// File: rtl/dct_flags.sv
// Module: sticky request flags. A hardware set wins over a write-one clear in the same cycle.
module dct_flags #(
    parameter int NF = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NF-1:0] set,
    input  logic [NF-1:0] clr,
    output logic [NF-1:0] flag
);

    // Set has priority, clear only drops bits not being set
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= '0;
        else        flag <= set | (flag & ~clr);
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((flag & $past(set)) == $past(set))) else $error("set flag not visible"); // R9

endmodule

// File: rtl/dual_cmp_timer.sv
// Module: top of the dual compare timer. Ties the register file, counter core, waveform channels and flags together.
// Assumes tick is a single-cycle strobe in the clk domain.
module dual_cmp_timer
    import timer_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] count,
    output logic          wave_a,
    output logic          wave_b,
    output logic          irq_ovf,
    output logic          irq_cmp_a,
    output logic          irq_cmp_b
);

    localparam int NCH = 2;

    tmr_mode_e          mode;
    logic [NCH-1:0]     out_en, match, wave;
    logic [DW-1:0]      cmp_a, cmp_b;
    logic               cnt_wr, load_top, dir_up, ovf_evt;
    logic [NFLAG-1:0]   clr_mask, flag;

    dct_regs #(.DW(DW)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .load_top(load_top), .mode(mode), .out_en(out_en), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cnt_wr(cnt_wr), .clr_mask(clr_mask)
    );

    dct_core #(.DW(DW)) i_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .cnt_wr(cnt_wr), .cnt_wdata(wr_data), .cnt(count), .dir_up(dir_up),
        .match(match), .ovf_evt(ovf_evt), .at_top(load_top)
    );

    dct_wave #(.NCH(NCH)) i_wave (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dir_up(dir_up),
        .match(match), .out_en(out_en), .wave(wave)
    );

    dct_flags #(.NF(NFLAG)) i_flags (
        .clk(clk), .rst_n(rst_n), .set({match[1], match[0], ovf_evt}),
        .clr(clr_mask), .flag(flag)
    );

    assign wave_a    = wave[0];
    assign wave_b    = wave[1];
    assign irq_ovf   = flag[0];
    assign irq_cmp_a = flag[1];
    assign irq_cmp_b = flag[2];

endmodule

// File: tb/test_dual_cmp_timer.sv
module test_dual_cmp_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] count;
    logic       wave_a, wave_b, irq_ovf, irq_cmp_a, irq_cmp_b;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // expected state, built from the requirements
    logic [7:0] mc, mbuf[2], mact[2];
    logic [3:0] mctl;
    logic       mdir, msup;
    logic       mw[2];
    logic [2:0] mf;

    dual_cmp_timer i_dual_cmp_timer (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .count(count), .wave_a(wave_a), .wave_b(wave_b),
        .irq_ovf(irq_ovf), .irq_cmp_a(irq_cmp_a), .irq_cmp_b(irq_cmp_b)
    );

    always #4 clk = !clk;   // 125 MHz

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        mc = 0; mdir = 1; msup = 0; mctl = 0; mf = 0;
        for (int i = 0; i < 2; i++) begin mbuf[i] = 0; mact[i] = 0; mw[i] = 0; end
    endtask

    task automatic model_step(bit t, bit we, logic [2:0] a, logic [7:0] d);
        logic       pwm, ovf, attop;
        logic [1:0] mode;
        logic [7:0] eff[2];
        logic [7:0] top, nc;
        logic       nd, ns;
        logic       m[2];
        logic [2:0] clr;
        pwm = mctl[1]; mode = mctl[1:0];
        for (int i = 0; i < 2; i++) begin eff[i] = pwm ? mact[i] : mbuf[i]; m[i] = 0; end
        top = (mode == 2'd0 || mode == 2'd2) ? 8'hFF : eff[0];
        nc = mc; nd = mdir; ns = msup; ovf = 0; attop = 0;
        if (we && a == 3'd0) begin
            nc = d; ns = 1;
        end else if (t) begin
            ns = 0;
            for (int i = 0; i < 2; i++) m[i] = !msup && (mc == eff[i]);
            case (mode)
                2'd0: begin nc = mc + 8'd1; ovf = (mc == 8'hFF); end
                2'd1: begin nc = (mc == top) ? 8'd0 : mc + 8'd1; ovf = (mc == 8'hFF); end
                default: begin
                    if (mdir) begin
                        if (mc >= top) begin nd = 0; attop = 1; nc = (mc == 0) ? 8'd0 : mc - 8'd1; end
                        else nc = mc + 8'd1;
                    end else if (mc == 0) begin
                        nd = 1; ovf = 1; nc = (top == 0) ? 8'd0 : 8'd1;
                    end else nc = mc - 8'd1;
                end
            endcase
        end
        for (int i = 0; i < 2; i++)
            if (mctl[2+i] && m[i]) begin
                if (pwm && !(i == 0 && mode == 2'd3)) mw[i] = !mdir;
                else                                    mw[i] = !mw[i];
            end
        for (int i = 0; i < 2; i++) if (!pwm || attop) mact[i] = mbuf[i];
        if (we && a == 3'd1) mbuf[0] = d;
        if (we && a == 3'd2) mbuf[1] = d;
        if (we && a == 3'd3) mctl = d[3:0];
        clr = (we && a == 3'd4) ? d[2:0] : 3'd0;
        mf = {m[1], m[0], ovf} | (mf & ~clr);
        mc = nc; mdir = nd; msup = ns;
    endtask

    task automatic compare_all();
        string ct, wt;
        ct = (mctl[1:0] == 2'd0) ? "R2 count" : (mctl[1:0] == 2'd1) ? "R3 count" : "R5 count";
        chk(ct, count, mc);
        wt = !mctl[2] ? "R11 wave_a" : mctl[1] ? "R6 wave_a" : "R4 wave_a";
        chk(wt, wave_a, mw[0]);
        wt = !mctl[3] ? "R11 wave_b" : mctl[1] ? "R6 wave_b" : "R4 wave_b";
        chk(wt, wave_b, mw[1]);
        chk(mctl[1] ? "R5 irq_ovf" : "R2 irq_ovf", irq_ovf, mf[0]);
        chk(mctl[1] ? "R7 irq_cmp_a" : "R8 irq_cmp_a", irq_cmp_a, mf[1]);
        chk(mctl[1] ? "R7 irq_cmp_b" : "R8 irq_cmp_b", irq_cmp_b, mf[2]);
    endtask

    // one clock: drive after the falling edge, check at the next falling edge
    task automatic cyc(bit t, bit we = 0, logic [2:0] a = 0, logic [7:0] d = 0);
        tick = t; wr_en = we; wr_addr = a; wr_data = d;
        model_step(t, we, a, d);
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            $display("FAIL watchdog actual %0d expected below 200000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        logic oldw;
        void'($urandom(32'd1234));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 count", count, 0);
        chk("R1 wave_a", wave_a, 0);
        chk("R1 wave_b", wave_b, 0);
        chk("R1 flags", {irq_cmp_b, irq_cmp_a, irq_ovf}, 0);

        // R2 wrap sets overflow
        cyc(0, 1, 3'd3, 8'h00);
        cyc(0, 1, 3'd0, 8'hFE);
        cyc(1);
        cyc(0);
        chk("R2 hold without tick", count, 8'hFF);
        cyc(1);
        chk("R2 wrap", count, 8'h00);
        chk("R2 overflow flag", irq_ovf, 1);

        // R9 clear, and set beating clear
        cyc(0, 1, 3'd4, 8'h01);
        chk("R9 cleared", irq_ovf, 0);
        cyc(0, 1, 3'd0, 8'hFF);
        cyc(1, 1, 3'd4, 8'h01);
        chk("R9 set wins", irq_ovf, 1);
        cyc(0, 1, 3'd4, 8'h01);
        chk("R9 cleared again", irq_ovf, 0);

        // R10 match suppression after a count write, write beats tick
        cyc(0, 1, 3'd4, 8'h07);
        cyc(0, 1, 3'd1, 8'h05);
        cyc(0, 1, 3'd0, 8'h05);
        cyc(1);
        chk("R10 suppressed match", irq_cmp_a, 0);
        chk("R10 count advanced", count, 8'h06);
        cyc(1, 1, 3'd0, 8'h03);
        chk("R10 write beats tick", count, 8'h03);
        cyc(1); cyc(1); cyc(1);
        chk("R10 match after window", irq_cmp_a, 1);

        // R3 clear on compare A
        cyc(0, 1, 3'd3, 8'h01);
        cyc(0, 1, 3'd0, 8'h00);
        repeat (6) cyc(1);
        chk("R3 cleared after A", count, 8'h00);

        // R4 toggle on match
        cyc(0, 1, 3'd3, 8'h05);
        oldw = wave_a;
        repeat (6) cyc(1);
        chk("R4 toggle", wave_a, !oldw);

        // R7 / R6 buffered compare in full-range up/down mode
        cyc(0, 1, 3'd2, 8'h10);
        cyc(0, 1, 3'd3, 8'h0A);
        cyc(0, 1, 3'd0, 8'h20);
        cyc(0, 1, 3'd2, 8'h30);
        cyc(0, 1, 3'd4, 8'h07);
        repeat (17) cyc(1);
        chk("R7 pending value unused", irq_cmp_b, 0);
        chk("R5 rising", count, 8'h31);
        for (int k = 0; k < 600 && count != 8'h2F; k++) cyc(1);
        chk("R7 loaded at top", irq_cmp_b, 1);
        chk("R6 set on down match", wave_b, 1);

        // constrained random
        for (int n = 0; n < 30000; n++) begin
            bit t, we;
            logic [2:0] a;
            logic [7:0] d;
            int r;
            t  = ($urandom % 3) != 0;
            we = ($urandom % 48) == 0;
            d  = 8'($urandom);
            r  = $urandom % 8;
            case (r)
                0:       a = 3'd0;
                1, 2:    a = 3'd1;
                3, 4:    a = 3'd2;
                5:       a = (($urandom % 4) == 0) ? 3'd3 : 3'd2;
                default: a = 3'd4;
            endcase
            cyc(t, we, a, d);
        end
        finish_run();
    end

endmodule